// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is an I2C bus master for reading from a slave device. A host drives it through four byte-wide registers. Each bus sequence has its own request bit: a START condition, the address byte, a received data byte, the acknowledge bit the master returns, and a STOP condition. The engine runs one sequence at a time and then returns to idle. Every completed sequence raises one interrupt flag, which stays set until the host writes it.

SCL is timed by a reload counter. Each counter rollover flips the SCL phase, so each SCL half-period is DIV+1 clock cycles. After the eighth received bit the engine holds SCL low until the host asks for the acknowledge. This stretches the bus clock while software reads the byte. The status register also reports buffer-full, receive overflow, write collision and the acknowledge bit sampled from the slave.

Both bus lines are open-drain. Each line has an output that pulls it low when set and an input that senses the real level. While the engine has released SCL and SCL still reads low, the counter waits.

Register map (`addr`):
- 0 DATA: a write sends an address byte. A read returns the last received byte.
- 1 CTRL: bit0 start, bit1 stop, bit2 receive, bit3 acknowledge, bit4 acknowledge value.
- 2 STAT: bit0 full, bit1 overflow, bit2 collision, bit3 slave acknowledge, bit4 interrupt, bit5 busy. A write loads bits 1, 2 and 4.
- 3 DIV: the baud reload value.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, CTRL and STAT read 0, DIV reads DIV_RESET, both bus lines are released and `irq` is 0.
- R2: Setting CTRL bit0 while idle pulls SDA low while SCL is high, then pulls SCL low. It then sets the interrupt flag and CTRL bit0 reads 0.
- R3: A DATA write while idle shifts the byte out MSB first. SDA is stable while SCL is high. Bit 0 of the byte is the read/write bit, and 1 means read.
- R4: On the ninth clock of the address byte, the level on SDA is stored in STAT bit3 (0 = slave ACK, 1 = NACK). The interrupt flag is set when that clock ends.
- R5: Setting CTRL bit2 while idle releases SDA and clocks in eight bits, MSB first. On the eighth falling SCL edge, the byte appears on DATA reads, STAT bit0 sets, CTRL bit2 clears and the interrupt flag sets.
- R6: After a received byte, SCL stays held low and STAT bit5 reads 0 until the host issues a new request.
- R7: A host read of DATA clears STAT bit0.
- R8: Setting CTRL bit3 drives CTRL bit4 onto SDA for one SCL clock (0 = ACK, 1 = NACK). It then sets the interrupt flag and clears CTRL bit3.
- R9: If a byte completes while STAT bit0 is still set, STAT bit1 sets. The buffer takes the new byte.
- R10: A DATA write while a sequence is running sets STAT bit2. It does not start a transmission and does not disturb the byte being received.
- R11: CTRL request bits written while the engine is busy are ignored. When several request bits are written together while idle, only one is accepted, in the order start, stop, receive, acknowledge.
- R12: Setting CTRL bit1 releases SCL first and then releases SDA while SCL is high. It sets the interrupt flag and leaves both lines released.
- R13: The interrupt flag only clears when the host writes 0 to STAT bit4.
- R14: Each SCL high phase lasts DIV+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Register read data, combinational on `addr` |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_in | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
The bench builds the engine with DIV_W=4 and DIV_RESET=2. This keeps every bit to a few cycles, so a full START, address, multi-byte receive and STOP session fits in a short run. The narrow divider also lets the bench reprogram DIV to 5 during the run and compare the measured SCL high time against both reload values. A bench-side slave drives SDA bit by bit on falling SCL edges, so received bytes, ACK/NACK levels, overflow and collision all show up at the ports.

// File: rtl/i2c_rx_master.sv
module i2c_rx_master #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_ACK, S_STOP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div, cnt;
  logic             hi;
  logic [3:0]       bitn;
  logic [7:0]       sh, rxb;
  logic             go_start, go_stop, rx_en, ack_go, ack_val;
  logic             full, ovf, wcol, ack_in, irq_q;
  logic             scl_low, sda_low;

  wire wr_data = wr_en && addr == 2'd0;
  wire wr_ctrl = wr_en && addr == 2'd1;
  wire wr_stat = wr_en && addr == 2'd2;
  wire wr_div  = wr_en && addr == 2'd3;
  wire rd_data = rd_en && addr == 2'd0;
  wire idle    = st == S_IDLE;
  wire stretch = !idle && !scl_low && !scl_in;
  wire tick    = !idle && cnt == '0;

  assign irq    = irq_q;
  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  always_comb begin
    case (addr)
      2'd0:    rdata = rxb;
      2'd1:    rdata = {3'b000, ack_val, ack_go, rx_en, go_stop, go_start};
      2'd2:    rdata = {2'b00, !idle, irq_q, ack_in, wcol, ovf, full};
      default: rdata = 8'(div);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     cnt <= DIV_W'(DIV_RESET);
    else if (idle || stretch || tick) cnt <= div;
    else                            cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= DIV_W'(DIV_RESET); hi <= 1'b0; bitn <= '0;
      sh <= '0; rxb <= '0;
      go_start <= 1'b0; go_stop <= 1'b0; rx_en <= 1'b0; ack_go <= 1'b0; ack_val <= 1'b0;
      full <= 1'b0; ovf <= 1'b0; wcol <= 1'b0; ack_in <= 1'b0; irq_q <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      if (wr_div) div <= DIV_W'(wdata);
      if (wr_stat) begin
        ovf <= wdata[1]; wcol <= wdata[2]; irq_q <= wdata[4];
      end
      if (rd_data) full <= 1'b0;
      if (wr_ctrl) begin
        ack_val <= wdata[4];
        if (idle) begin
          hi <= 1'b0; bitn <= '0;
          if (wdata[0]) begin
            go_start <= 1'b1; st <= S_START; sda_low <= 1'b1;
          end else if (wdata[1]) begin
            go_stop <= 1'b1; st <= S_STOP; sda_low <= 1'b1;
          end else if (wdata[2]) begin
            rx_en <= 1'b1; st <= S_RX; sda_low <= 1'b0;
          end else if (wdata[3]) begin
            ack_go <= 1'b1; st <= S_ACK; sda_low <= !wdata[4];
          end
        end
      end
      if (wr_data) begin
        if (idle) begin
          sh <= wdata; st <= S_TX; sda_low <= !wdata[7]; hi <= 1'b0; bitn <= '0;
        end else wcol <= 1'b1;
      end
      if (tick) begin
        if (!hi && st != S_START) begin
          scl_low <= 1'b0; hi <= 1'b1;
        end else begin
          hi <= 1'b0;
          case (st)
            S_START: begin
              scl_low <= 1'b1; go_start <= 1'b0; irq_q <= 1'b1; st <= S_IDLE;
            end
            S_TX: begin
              scl_low <= 1'b1;
              if (bitn == 4'd8) begin
                ack_in <= sda_in; irq_q <= 1'b1; st <= S_IDLE;
              end else begin
                bitn    <= bitn + 4'd1;
                sh      <= {sh[6:0], 1'b0};
                sda_low <= (bitn == 4'd7) ? 1'b0 : !sh[6];
              end
            end
            S_RX: begin
              scl_low <= 1'b1;
              sh      <= {sh[6:0], sda_in};
              if (bitn == 4'd7) begin
                rxb   <= {sh[6:0], sda_in};
                full  <= 1'b1;
                if (full && !rd_data) ovf <= 1'b1;
                rx_en <= 1'b0; irq_q <= 1'b1; st <= S_IDLE;
              end else bitn <= bitn + 4'd1;
            end
            S_ACK: begin
              scl_low <= 1'b1; sda_low <= 1'b0; ack_go <= 1'b0; irq_q <= 1'b1; st <= S_IDLE;
            end
            S_STOP: begin
              sda_low <= 1'b0; go_stop <= 1'b0; irq_q <= 1'b1; st <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_start, go_stop, rx_en, ack_go}));

  assert_hold_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_RX) |-> (scl_oe && full && !rx_en));

  assert_irq_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_stat) |=> irq_q);

  assert_read_clears_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && st != S_RX) |=> !full);

  assert_sda_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && !scl_low && $past(st == S_TX && !scl_low)) |-> $stable(sda_low));

endmodule

// File: tb/i2c_rx_master_tb.sv
module i2c_rx_master_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 1'b0;
  wire  scl_line = !scl_oe;
  wire  sda_line = !sda_oe && !slv_low;

  int tests = 0, fails = 0;
  logic start_seen = 1'b0, stop_seen = 1'b0;

  always #2 clk = ~clk;

  i2c_rx_master #(.DIV_W(4), .DIV_RESET(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_in(scl_line), .scl_oe(scl_oe),
    .sda_in(sda_line), .sda_oe(sda_oe));

  always @(negedge sda_line) if (scl_line === 1'b1) start_seen = 1'b1;
  always @(posedge sda_line) if (scl_line === 1'b1) stop_seen = 1'b1;

  localparam logic [8:0] VEC [6] = '{
    {8'hA5, 1'b0}, {8'h00, 1'b0}, {8'hFF, 1'b0},
    {8'h81, 1'b0}, {8'h7E, 1'b0}, {8'h96, 1'b1}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = (a == 2'd0);
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(irq === 1'b1, tag, irq, 1);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    slv_low = !b[7];
    wr(2'd1, 8'h04);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line); @(negedge scl_line);
      if (i < 7) slv_low = !b[6-i];
    end
    slv_low = 1'b0;
    wait_irq("R5 irq after byte");
  endtask

  task automatic do_ack(input logic av, output logic s, output int n);
    wr(2'd2, 8'h00);
    wr(2'd1, av ? 8'h18 : 8'h08);
    @(posedge scl_line); s = sda_line; n = 0;
    while (scl_line) begin @(posedge clk); #1; n++; end
    wait_irq("R8 irq after ack");
    wr(2'd2, 8'h00);
  endtask

  task automatic send_addr(input logic [7:0] a, input logic ack, output logic [7:0] cap);
    cap = 8'h00;
    wr(2'd0, a);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line); cap = {cap[6:0], sda_line};
      @(negedge scl_line);
    end
    slv_low = (ack == 1'b0);
    wait_irq("R4 irq after address");
    slv_low = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, cap;
    logic s;
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, d); chk(d == 8'h00, "R1 STAT", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 CTRL", d, 0);
    rd(2'd3, d); chk(d == 8'h02, "R1 DIV", d, 2);
    chk(!scl_oe && !sda_oe && !irq, "R1 lines/irq", {scl_oe, sda_oe, irq}, 0);

    // R2 START
    start_seen = 1'b0;
    wr(2'd1, 8'h01);
    wait_irq("R2 irq");
    chk(start_seen, "R2 start condition", start_seen, 1);
    chk(!scl_line && !sda_line, "R2 lines low", {scl_line, sda_line}, 0);
    rd(2'd1, d); chk(d[0] == 1'b0, "R2 start bit cleared", d, 0);
    wr(2'd2, 8'h00);

    // R3/R4 address, slave NACK
    send_addr({7'h50, 1'b1}, 1'b1, cap);
    chk(cap == 8'hA1, "R3 address byte", cap, 8'hA1);
    rd(2'd2, d); chk(d[3] == 1'b1, "R4 slave nack", d[3], 1);
    wr(2'd2, 8'h00);

    // R5..R8 table walk
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      logic av;
      b = VEC[i][8:1]; av = VEC[i][0];
      rx_byte(b);
      rd(2'd2, d); chk(d[0] == 1'b1, "R5 full set", d[0], 1);
      rd(2'd1, d); chk(d[2] == 1'b0, "R5 rx bit cleared", d[2], 0);
      repeat (20) @(negedge clk);
      rd(2'd2, d);
      chk(scl_oe == 1'b1 && d[5] == 1'b0, "R6 SCL held, idle", {scl_oe, d[5]}, 2);
      rd(2'd0, d); chk(d == b, "R5 received byte", d, b);
      rd(2'd2, d); chk(d[0] == 1'b0, "R7 full cleared", d[0], 0);
      do_ack(av, s, n);
      chk(s == av, "R8 ack level", s, av);
      rd(2'd1, d); chk(d == {3'b0, av, 4'b0}, "R8 ack bit cleared", d, {3'b0, av, 4'b0});
      if (i == 0) chk(n == 3, "R14 high phase div=2", n, 3);
    end

    // R9 overflow
    rx_byte(8'h3C); wr(2'd2, 8'h00); do_ack(1'b0, s, n);
    rx_byte(8'hC3);
    rd(2'd2, d); chk(d[1] == 1'b1, "R9 overflow set", d[1], 1);
    rd(2'd0, d); chk(d == 8'hC3, "R9 buffer new byte", d, 8'hC3);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk(d[1] == 1'b0, "R9 overflow cleared by write", d[1], 0);
    do_ack(1'b0, s, n);

    // R10 collision, R11 ignored request while busy
    fork
      rx_byte(8'h5A);
      begin
        @(posedge scl_line);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h02);
        rd(2'd1, d); chk(d == 8'h04, "R11 stop ignored while busy", d, 8'h04);
      end
    join
    rd(2'd2, d); chk(d[2] == 1'b1, "R10 collision set", d[2], 1);
    rd(2'd0, d); chk(d == 8'h5A, "R10 receive undisturbed", d, 8'h5A);
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk(d[5] == 1'b0 && scl_oe, "R11 stays idle", {d[5], scl_oe}, 1);

    // R13 sticky irq
    repeat (50) @(negedge clk);
    chk(irq == 1'b1, "R13 irq held", irq, 1);
    wr(2'd2, 8'h00);
    chk(irq == 1'b0, "R13 irq cleared by write", irq, 0);
    do_ack(1'b0, s, n);

    // R14 reprogrammed divider
    wr(2'd3, 8'h05);
    rx_byte(8'h69);
    rd(2'd0, d); chk(d == 8'h69, "R5 byte at div=5", d, 8'h69);
    wr(2'd2, 8'h00);
    do_ack(1'b1, s, n);
    chk(n == 6, "R14 high phase div=5", n, 6);
    chk(s == 1'b1, "R8 nack level", s, 1);

    // R12 STOP
    stop_seen = 1'b0;
    wr(2'd1, 8'h02);
    wait_irq("R12 irq");
    chk(stop_seen, "R12 stop condition", stop_seen, 1);
    chk(scl_line && sda_line, "R12 lines released", {scl_line, sda_line}, 3);
    wr(2'd2, 8'h00);

    // R4 with slave ACK, then R11 priority
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h01); wait_irq("R2 irq second start"); wr(2'd2, 8'h00);
    send_addr(8'h9F, 1'b0, cap);
    chk(cap == 8'h9F, "R3 second address", cap, 8'h9F);
    rd(2'd2, d); chk(d[3] == 1'b0, "R4 slave ack", d[3], 0);
    wr(2'd2, 8'h00);
    stop_seen = 1'b0;
    wr(2'd1, 8'h06);
    rd(2'd1, d); chk(d == 8'h02, "R11 stop beats receive", d, 8'h02);
    wait_irq("R12 irq priority stop");
    chk(stop_seen, "R12 stop after priority", stop_seen, 1);
    rd(2'd1, d); chk(d == 8'h00, "R11 no receive queued", d, 0);

    summary();
  end

endmodule